// File: doc/BRIEF.md
# Programmable Flow-Chart Sequencer

This block is a synchronous control unit that runs a control flow chart stored as 16-bit words in a small program memory. Each flow-chart step takes two cycles of the single system clock. In the first cycle, the sample cycle, the input vector is captured into an input register. In the second cycle, the execute cycle, the word at the current phase address is carried out. Output and internal flags are set or cleared, and the phase address moves on when the step's transition condition holds.

Software or a host loads the program through a write port while the unit is idle, then pulses `start`. The unit runs from address 0 until it executes a halt word. The supported steps are flag set and clear, conditional jumps on a sampled input or an internal flag, waits for an input level, and delays counted in whole steps.

Top module: `flowchart_sequencer`

## Requirements
- R1: A synchronous reset clears every output flag, every internal flag and `busy`, and sets the phase address to 0.
- R2: A `start` seen while idle raises `busy` at that edge and begins execution at address 0. Step k of a run (k counted from 1) takes effect at the 2k-th clock edge after the start edge.
- R3: Inputs are captured only at the end of the sample cycle. Flags and the phase address change only at the execute edge. An input level present only across an execute edge is never seen.
- R4: The word layout is [15:13] opcode, [12] bank, [11:8] index, [7:0] argument. Opcode 0 sets and opcode 1 clears the flag at that index. Bank 0 selects output flags and bank 1 selects internal flags. All other flags hold, and the step advances to the next address.
- R5: Opcode 2 jumps to the argument address when the tested bit is 1 and otherwise goes to the next address. Opcode 3 does the same when the tested bit is 0. The tested bit is the sampled input at the index for bank 0, or the internal flag at the index for bank 1.
- R6: Opcode 4 (wait for 1) and opcode 5 (wait for 0) hold the phase address while the sampled input at the index differs from the awaited level. They advance once it matches.
- R7: Opcode 6 occupies max(argument, 1) steps and then advances.
- R8: Opcode 7 drops `busy` at its execute edge. Flags keep their values, and a later `start` runs again from address 0.
- R9: Program writes are ignored while `busy` is high and accepted while idle.
- R10: A flag written in one step is seen with its new value by a test in the following step.
- R11: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run from address 0 when idle |
| in_vec | input | NIN | Condition inputs |
| out_flags | output | NOUT | Output flag register |
| busy | output | 1 | High from start until halt |
| wr_en | input | 1 | Program write strobe |
| wr_addr | input | AW | Program write address |
| wr_data | input | 16 | Program word |

## Verification
The assertions assume the loaded program is well formed. Indices stay within the configured input and flag counts, jump targets land on written words, and each step names a single flag, so a set and a clear never meet on one flag. The stimulus loads only such programs and writes every address a run can reach. It changes inputs one time unit after a clock edge and holds them as whole-cycle levels. Write and start pulses during a run are deliberate and are used only to show that they are ignored.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
   localparam int WORD_W = 16;
   localparam int IDX_W  = 4;
   localparam int ARG_W  = 8;
   localparam int SEL_N  = 1 << IDX_W;

   typedef enum logic [2:0] {
      OP_SET    = 3'd0,
      OP_CLR    = 3'd1,
      OP_JMP_T  = 3'd2,
      OP_JMP_F  = 3'd3,
      OP_WAIT_T = 3'd4,
      OP_WAIT_F = 3'd5,
      OP_DELAY  = 3'd6,
      OP_HALT   = 3'd7
   } fcs_op_e;

   typedef struct packed {
      fcs_op_e          op;
      logic             bank;
      logic [IDX_W-1:0] idx;
      logic [ARG_W-1:0] arg;
   } fcs_word_t;
endpackage

// File: rtl/fcs_prog_mem.sv
`timescale 1ns/1ps
module fcs_prog_mem #(
   parameter int AW = 8,
   parameter int W  = 16
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          lock,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && !lock) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fcs_flag_bank.sv
`timescale 1ns/1ps
module fcs_flag_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   output logic [N-1:0] q
);
   for (genvar b = 0; b < N; b++) begin : g_bit
      logic r;
      always_ff @(posedge clk) begin
         if (rst) r <= 1'b0;
         else if (tick) begin
            case ({set_v[b], clr_v[b]})
               2'b10:   r <= 1'b1;
               2'b01:   r <= 1'b0;
               2'b11:   r <= ~r;
               default: r <= r;
            endcase
         end
      end
      assign q[b] = r;
   end

   // R4: a step never sets and clears the same flag
   a_r4_no_set_clr_clash: assert property (@(posedge clk) disable iff (rst)
      tick |-> ((set_v & clr_v) == '0));

   // R4: strobes from the decoder arrive only in an execute cycle
   a_r4_strobes_in_execute: assert property (@(posedge clk) disable iff (rst)
      (|(set_v | clr_v)) |-> tick);

   // R3: flags move only at the execute edge
   a_r3_flags_only_on_execute: assert property (@(posedge clk) disable iff (rst)
      (!rst && !tick) |=> $stable(q));
endmodule

// File: rtl/fcs_phase_ctrl.sv
`timescale 1ns/1ps
module fcs_phase_ctrl
   import fcs_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  fcs_op_e          op,
   input  logic [ARG_W-1:0] arg,
   input  logic             cond,
   output logic             busy,
   output logic             sample,
   output logic             execute,
   output logic [AW-1:0]    pc
);
   logic             ph;
   logic             dly_on;
   logic [ARG_W-1:0] dly_left;
   logic             go;
   logic [AW-1:0]    pc_inc;
   logic [AW-1:0]    pc_tgt;
   logic [AW-1:0]    jmp_addr;

   assign sample   = busy & ~ph;
   assign execute  = busy & ph;
   assign pc_inc   = pc + AW'(1);
   assign jmp_addr = arg[AW-1:0];

   // transition enable: OR over the exits of the current phase
   always_comb begin
      go     = 1'b0;
      pc_tgt = pc_inc;
      case (op)
         OP_SET, OP_CLR: go = 1'b1;
         OP_JMP_T: begin
            go = 1'b1;
            if (cond) pc_tgt = jmp_addr;
         end
         OP_JMP_F: begin
            go = 1'b1;
            if (!cond) pc_tgt = jmp_addr;
         end
         OP_WAIT_T: go = cond;
         OP_WAIT_F: go = ~cond;
         OP_DELAY:  go = dly_on ? (dly_left == ARG_W'(1)) : (arg <= ARG_W'(1));
         default:   go = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy     <= 1'b0;
         ph       <= 1'b0;
         pc       <= '0;
         dly_on   <= 1'b0;
         dly_left <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            ph     <= 1'b0;
            pc     <= '0;
            dly_on <= 1'b0;
         end
      end else begin
         ph <= ~ph;
         if (ph) begin
            if (go) pc <= pc_tgt;
            if (op == OP_HALT) busy <= 1'b0;
            if (op == OP_DELAY) begin
               if (dly_on) begin
                  if (dly_left == ARG_W'(1)) dly_on <= 1'b0;
                  else dly_left <= dly_left - ARG_W'(1);
               end else if (arg > ARG_W'(1)) begin
                  dly_on   <= 1'b1;
                  dly_left <= arg - ARG_W'(1);
               end
            end
         end
      end
   end

   // R2: start from idle enters the initial phase in the sample cycle
   a_r2_start_at_origin: assert property (@(posedge clk) disable iff (rst)
      (!busy && start) |=> (busy && pc == '0 && !ph));

   // R3: the phase address holds through every sample cycle
   a_r3_phase_only_on_execute: assert property (@(posedge clk) disable iff (rst)
      (busy && !ph) |=> $stable(pc));

   // R6: an unmet wait keeps the phase and the run
   a_r6_wait_holds: assert property (@(posedge clk) disable iff (rst)
      (execute && ((op == OP_WAIT_T && !cond) || (op == OP_WAIT_F && cond)))
      |=> ($stable(pc) && busy));

   // R7: an active delay always has steps left
   a_r7_delay_left_nonzero: assert property (@(posedge clk) disable iff (rst)
      dly_on |-> (dly_left != '0));

   // R8: halt ends the run
   a_r8_halt_drops_busy: assert property (@(posedge clk) disable iff (rst)
      (execute && op == OP_HALT) |=> !busy);
endmodule

// File: rtl/flowchart_sequencer.sv
`timescale 1ns/1ps
module flowchart_sequencer
   import fcs_pkg::*;
#(
   parameter int NIN  = 8,
   parameter int NOUT = 8,
   parameter int NINT = 4,
   parameter int AW   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [NIN-1:0]    in_vec,
   output logic [NOUT-1:0]   out_flags,
   output logic              busy,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data
);
   if (NIN < 1 || NIN > SEL_N) begin : g_bad_nin
      $error("NIN must lie in 1..16");
   end
   if (NOUT < 1 || NOUT > SEL_N) begin : g_bad_nout
      $error("NOUT must lie in 1..16");
   end
   if (NINT < 1 || NINT > SEL_N) begin : g_bad_nint
      $error("NINT must lie in 1..16");
   end
   if (AW < 1 || AW > ARG_W) begin : g_bad_aw
      $error("AW must lie in 1..8");
   end

   logic [WORD_W-1:0] rd_data;
   fcs_word_t         w;
   logic [AW-1:0]     pc;
   logic              sample;
   logic              execute;
   logic              cond;
   logic [NIN-1:0]    in_q;
   logic [NINT-1:0]   int_q;
   logic [SEL_N-1:0]  in_ext;
   logic [SEL_N-1:0]  int_ext;
   logic [NOUT-1:0]   out_set, out_clr;
   logic [NINT-1:0]   int_set, int_clr;
   logic              is_jump;

   fcs_prog_mem #(.AW(AW), .W(WORD_W)) i_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .lock    (busy),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (pc),
      .rd_data (rd_data)
   );

   assign w = fcs_word_t'(rd_data);

   always_ff @(posedge clk) begin
      if (rst) in_q <= '0;
      else if (sample) in_q <= in_vec;
   end

   assign in_ext  = SEL_N'(in_q);
   assign int_ext = SEL_N'(int_q);
   assign is_jump = (w.op == OP_JMP_T) || (w.op == OP_JMP_F);
   assign cond    = (is_jump && w.bank) ? int_ext[w.idx] : in_ext[w.idx];

   always_comb begin
      for (int i = 0; i < NOUT; i++) begin
         out_set[i] = execute && w.op == OP_SET && !w.bank && w.idx == IDX_W'(i);
         out_clr[i] = execute && w.op == OP_CLR && !w.bank && w.idx == IDX_W'(i);
      end
      for (int i = 0; i < NINT; i++) begin
         int_set[i] = execute && w.op == OP_SET && w.bank && w.idx == IDX_W'(i);
         int_clr[i] = execute && w.op == OP_CLR && w.bank && w.idx == IDX_W'(i);
      end
   end

   fcs_flag_bank #(.N(NOUT)) i_out_bank (
      .clk   (clk),
      .rst   (rst),
      .tick  (execute),
      .set_v (out_set),
      .clr_v (out_clr),
      .q     (out_flags)
   );

   fcs_flag_bank #(.N(NINT)) i_int_bank (
      .clk   (clk),
      .rst   (rst),
      .tick  (execute),
      .set_v (int_set),
      .clr_v (int_clr),
      .q     (int_q)
   );

   fcs_phase_ctrl #(.AW(AW)) i_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .op      (w.op),
      .arg     (w.arg),
      .cond    (cond),
      .busy    (busy),
      .sample  (sample),
      .execute (execute),
      .pc      (pc)
   );

   // R3: the input register holds outside the sample cycle
   a_r3_inputs_only_in_sample: assert property (@(posedge clk) disable iff (rst)
      (!rst && !sample) |=> $stable(in_q));
endmodule

// File: tb/test_flowchart_sequencer.sv
`timescale 1ns/1ps
module test_flowchart_sequencer;
   localparam int PERIOD = 10;

   localparam logic [2:0] C_SET = 3'd0, C_CLR = 3'd1, C_JT = 3'd2, C_JF = 3'd3,
                          C_WT = 3'd4, C_WF = 3'd5, C_DLY = 3'd6, C_HLT = 3'd7;

   function automatic logic [15:0] mk(logic [2:0] op, logic bank, logic [3:0] idx, logic [7:0] arg);
      return {op, bank, idx, arg};
   endfunction

   // {word0, word1, inputs, expected flags, expected steps}
   localparam int NROW = 14;
   localparam logic [55:0] ROWS [NROW] = '{
      {mk(C_SET,0,0,0), mk(C_SET,0,2,0), 8'h00, 8'h85, 8'd4},
      {mk(C_SET,0,1,0), mk(C_CLR,0,1,0), 8'h00, 8'h80, 8'd4},
      {mk(C_JT,0,3,8),  mk(C_SET,0,0,0), 8'h08, 8'h40, 8'd3},
      {mk(C_JT,0,3,8),  mk(C_SET,0,0,0), 8'h00, 8'h81, 8'd4},
      {mk(C_JF,0,3,8),  mk(C_SET,0,0,0), 8'h00, 8'h40, 8'd3},
      {mk(C_JF,0,3,8),  mk(C_SET,0,0,0), 8'h08, 8'h81, 8'd4},
      {mk(C_SET,1,0,0), mk(C_JT,1,0,8),  8'h00, 8'h40, 8'd4},
      {mk(C_SET,0,3,0), mk(C_JF,1,1,8),  8'h00, 8'h48, 8'd4},
      {mk(C_WT,0,2,0),  mk(C_SET,0,0,0), 8'h04, 8'h81, 8'd4},
      {mk(C_WF,0,5,0),  mk(C_SET,0,0,0), 8'h04, 8'h81, 8'd4},
      {mk(C_DLY,0,0,3), mk(C_SET,0,0,0), 8'h00, 8'h81, 8'd6},
      {mk(C_DLY,0,0,2), mk(C_SET,0,0,0), 8'h00, 8'h81, 8'd5},
      {mk(C_DLY,0,0,0), mk(C_SET,0,0,0), 8'h00, 8'h81, 8'd4},
      {mk(C_SET,0,4,0), mk(C_HLT,0,0,0), 8'h00, 8'h10, 8'd2}
   };
   localparam string ROWTAG [NROW] = '{"R4","R4","R5","R5","R5","R5","R10",
                                       "R5","R6","R6","R7","R7","R7","R8"};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  in_vec = '0;
   logic [7:0]  out_flags;
   logic        busy;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   int          total = 0;
   int          bad = 0;

   flowchart_sequencer i_flowchart_sequencer (
      .clk(clk), .rst(rst), .start(start), .in_vec(in_vec), .out_flags(out_flags),
      .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always #(PERIOD/2) clk = ~clk;

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
   endtask

   task automatic finish_run(output int n);
      n = 0;
      while (busy && n < 400) begin
         tick();
         n++;
      end
   endtask

   task automatic run(output int n);
      start = 1'b1;
      tick();
      start = 1'b0;
      finish_run(n);
   endtask

   initial begin
      #(PERIOD * 150000);
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      chk("R1 busy after reset", 32'(busy), 0);
      chk("R1 flags after reset", 32'(out_flags), 0);

      wr(8'd2, mk(C_SET,0,7,0));
      wr(8'd3, mk(C_HLT,0,0,0));
      wr(8'd8, mk(C_SET,0,6,0));
      wr(8'd9, mk(C_HLT,0,0,0));

      for (int r = 0; r < NROW; r++) begin
         do_reset();
         wr(8'd0, ROWS[r][55:40]);
         wr(8'd1, ROWS[r][39:24]);
         in_vec = ROWS[r][23:16];
         run(n);
         chk($sformatf("%s row %0d flags", ROWTAG[r], r), 32'(out_flags), 32'(ROWS[r][15:8]));
         chk($sformatf("%s row %0d cycles", ROWTAG[r], r), 32'(n), 32'(ROWS[r][7:0]) * 2);
      end

      // R1: reset after a run clears the flags
      do_reset();
      chk("R1 flags cleared after run", 32'(out_flags), 0);
      chk("R1 busy cleared after run", 32'(busy), 0);

      // R2 / R3 / R8: cycle timing of a two-step run
      wr(8'd0, mk(C_SET,0,0,0));
      wr(8'd1, mk(C_HLT,0,0,0));
      start = 1'b1;
      tick();
      start = 1'b0;
      chk("R2 busy at start edge", 32'(busy), 1);
      tick();
      chk("R3 no flag change on sample edge", 32'(out_flags), 0);
      tick();
      chk("R2 first step at edge 2", 32'(out_flags), 32'h01);
      tick();
      chk("R8 busy before halt edge", 32'(busy), 1);
      tick();
      chk("R8 busy after halt edge", 32'(busy), 0);

      // R8: rerun from address 0, flags kept
      wr(8'd0, mk(C_SET,0,1,0));
      run(n);
      chk("R8 rerun keeps flags", 32'(out_flags), 32'h03);
      chk("R8 rerun cycles", 32'(n), 4);

      // R3: input high only across an execute edge is missed
      do_reset();
      wr(8'd0, mk(C_WT,0,2,0));
      wr(8'd1, mk(C_SET,0,0,0));
      in_vec = 8'h00;
      start = 1'b1;
      tick();
      start = 1'b0;
      tick();
      in_vec = 8'h04;
      tick();
      in_vec = 8'h00;
      repeat (10) tick();
      chk("R3 pulse on execute edge missed busy", 32'(busy), 1);
      chk("R3 pulse on execute edge missed flags", 32'(out_flags), 0);
      in_vec = 8'h04;
      finish_run(n);
      chk("R6 wait released", 32'(out_flags), 32'h81);

      // R6 / R9 / R11: a wait that is held, a write and a start during the run
      do_reset();
      wr(8'd0, mk(C_JT,1,0,8));
      wr(8'd1, mk(C_SET,1,0,0));
      wr(8'd2, mk(C_WT,0,2,0));
      wr(8'd3, mk(C_SET,0,0,0));
      wr(8'd4, mk(C_HLT,0,0,0));
      in_vec = 8'h00;
      start = 1'b1;
      tick();
      start = 1'b0;
      repeat (6) tick();
      start = 1'b1;
      tick();
      start = 1'b0;
      wr(8'd3, mk(C_SET,0,5,0));
      repeat (6) tick();
      chk("R6 wait holds busy", 32'(busy), 1);
      chk("R6 wait holds flags", 32'(out_flags), 0);
      in_vec = 8'h04;
      finish_run(n);
      chk("R9 write during run ignored", 32'(out_flags[5]), 0);
      chk("R11 start during run ignored", 32'(out_flags[6]), 0);
      chk("R6 run completes after wait", 32'(out_flags), 32'h01);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule